// File: doc/BRIEF.md
# Flag-Setting Arithmetic-Logic Unit

This block is the execute unit of a small processor datapath. Each cycle it takes two operands, a third operand for accumulation, a four-bit operation code, a set-flags control bit and a valid strobe. From these it forms a 32-bit result in the same cycle. It also gives a write-enable that tells the register file whether to keep that result. The four condition flags (negative, zero, carry, overflow) live in a register inside the block. Their stored carry feeds the carry-chained add. The flags change at the next clock edge, and only when the operation is allowed to set them.

The operations are add, add with carry, subtract and reverse subtract, the four bitwise operations, move and move-inverted, and the low word of a multiply, with or without an accumulated term. There are also four compare-style operations that set flags and write no result. Negation is done as reverse subtract with a zero second operand. Chaining add-with-carry after a plain add gives sums wider than one word.

Top module: `flagAlu`

## Requirements
- R1: Operation code 0 (add) gives opA+opB. Code 1 (add with carry) gives opA+opB plus the stored carry flag. In both cases the flag update loads C with the carry out of bit 31.
- R2: Code 2 (subtract) gives opA-opB. Code 3 (reverse subtract) gives opB-opA. In both cases C is set when no borrow occurs, and V is set on signed overflow of the 32-bit difference.
- R3: Whenever the flags are updated, N takes bit 31 of the result and Z is set exactly when the result is all zeros.
- R4: Code 4 gives opA AND opB, code 5 gives opA OR opB, code 6 gives opA XOR opB, and code 7 (bit clear) gives opA AND NOT opB.
- R5: Code 12 (move) outputs opB, and code 13 (move inverted) outputs the bitwise complement of opB. opA has no effect on either.
- R6: Code 14 gives the low 32 bits of opA*opB. Code 15 gives the low 32 bits of opA*opB+opC.
- R7: A result-producing operation (codes 0-7 and 12-15) updates the flags only when opValid and setFlags are both high. In every other cycle all four flags keep their values.
- R8: The bitwise, move and multiply operations (codes 4-7 and 12-15) and the two test operations (codes 10 and 11) update only N and Z. C and V keep their values.
- R9: The compare operations update the flags whenever opValid is high, whatever setFlags is. Code 8 compares by opA-opB, code 9 by opA+opB, code 10 by opA AND opB, and code 11 by opA XOR opB. For all four, resWe stays low.
- R10: resWe is high in the same cycle exactly when opValid is high and the code is one of 0-7 or 12-15.
- R11: An active-low reset clears all four flags to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flags update on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the flags |
| opValid | input | 1 | An operation is presented this cycle |
| opSel | input | 4 | Operation code (see R1-R9 for values) |
| setFlags | input | 1 | Allow a result-producing operation to update the flags |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opC | input | 32 | Accumulate term for multiply-accumulate |
| resOut | output | 32 | Result, combinational |
| resWe | output | 1 | Result write-enable, combinational |
| flagN | output | 1 | Stored negative flag |
| flagZ | output | 1 | Stored zero flag |
| flagC | output | 1 | Stored carry flag |
| flagV | output | 1 | Stored overflow flag |

## Verification
Several rules hold on every cycle. The flags stay still unless a permitted update occurs, and the carry and overflow flags survive bitwise, move, multiply and test operations. Compares and idle cycles never raise the write-enable. After each result-writing update, N and Z agree with the result of the previous cycle. The arithmetic values themselves can only be shown by the bench's scenarios. These include the add-with-carry chain that consumes a carry left by an earlier operation, borrow and overflow at the sign boundary, negation through reverse subtract, wrap of the low multiply word, and flag clearing by a reset in mid-run.

// File: rtl/flagalu_pkg.sv
package flagalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_AND = 4'd4,  OP_ORR = 4'd5,  OP_XOR = 4'd6,  OP_BIC = 4'd7,
    OP_CMP = 4'd8,  OP_CMN = 4'd9,  OP_TST = 4'd10, OP_TEQ = 4'd11,
    OP_MOV = 4'd12, OP_MVN = 4'd13, OP_MUL = 4'd14, OP_MLA = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {
    SRC_ADDER = 2'd0,
    SRC_LOGIC = 2'd1,
    SRC_MUL   = 2'd2
  } srcSel_e;

  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_ORR  = 3'd1,
    LG_XOR  = 3'd2,
    LG_BIC  = 3'd3,
    LG_PASS = 3'd4,
    LG_INV  = 3'd5
  } logicFn_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cinSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    srcSel_e  src;
    logicFn_e lfn;
    cinSel_e  cin;
    logic     swapOps;
    logic     invSecond;
    logic     accum;
    logic     wrResult;
    logic     ldNZ;
    logic     ldCV;
  } aluStrobe_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } aluFlags_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import flagalu_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic       opValid,
  input  logic       setFlags,
  output aluStrobe_t strb
);

  logic isCompare;
  logic arithFlags;
  logic flagReq;

  always_comb begin
    strb       = '0;
    strb.src   = SRC_ADDER;
    strb.lfn   = LG_AND;
    strb.cin   = CIN_ZERO;
    isCompare  = 1'b0;
    arithFlags = 1'b0;
    unique case (aluOp_e'(opSel))
      OP_ADD: begin arithFlags = 1'b1; end
      OP_ADC: begin arithFlags = 1'b1; strb.cin = CIN_FLAG; end
      OP_SUB: begin arithFlags = 1'b1; strb.cin = CIN_ONE; strb.invSecond = 1'b1; end
      OP_RSB: begin
        arithFlags     = 1'b1;
        strb.cin       = CIN_ONE;
        strb.invSecond = 1'b1;
        strb.swapOps   = 1'b1;
      end
      OP_AND: begin strb.src = SRC_LOGIC; strb.lfn = LG_AND; end
      OP_ORR: begin strb.src = SRC_LOGIC; strb.lfn = LG_ORR; end
      OP_XOR: begin strb.src = SRC_LOGIC; strb.lfn = LG_XOR; end
      OP_BIC: begin strb.src = SRC_LOGIC; strb.lfn = LG_BIC; end
      OP_CMP: begin
        isCompare      = 1'b1;
        arithFlags     = 1'b1;
        strb.cin       = CIN_ONE;
        strb.invSecond = 1'b1;
      end
      OP_CMN: begin isCompare = 1'b1; arithFlags = 1'b1; end
      OP_TST: begin isCompare = 1'b1; strb.src = SRC_LOGIC; strb.lfn = LG_AND; end
      OP_TEQ: begin isCompare = 1'b1; strb.src = SRC_LOGIC; strb.lfn = LG_XOR; end
      OP_MOV: begin strb.src = SRC_LOGIC; strb.lfn = LG_PASS; end
      OP_MVN: begin strb.src = SRC_LOGIC; strb.lfn = LG_INV; end
      OP_MUL: begin strb.src = SRC_MUL; end
      OP_MLA: begin strb.src = SRC_MUL; strb.accum = 1'b1; end
      default: ;
    endcase
    flagReq       = opValid & (setFlags | isCompare);
    strb.wrResult = opValid & ~isCompare;
    strb.ldNZ     = flagReq;
    strb.ldCV     = flagReq & arithFlags;
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import flagalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  input  aluStrobe_t       strb,
  output logic [WIDTH-1:0] result,
  output aluFlags_t        flagQ
);

  localparam int MSB = WIDTH - 1;

  // Adder path: swap for reverse subtract, invert second input for subtract
  logic [WIDTH-1:0] addX, addY, addYEff;
  logic             cinBit;
  logic [WIDTH:0]   addSum;
  logic             addCarry, addOvf;

  always_comb begin
    addX    = strb.swapOps ? opB : opA;
    addY    = strb.swapOps ? opA : opB;
    addYEff = strb.invSecond ? ~addY : addY;
    unique case (strb.cin)
      CIN_ONE:  cinBit = 1'b1;
      CIN_FLAG: cinBit = flagQ.c;
      default:  cinBit = 1'b0;
    endcase
    addSum   = {1'b0, addX} + {1'b0, addYEff} + {{WIDTH{1'b0}}, cinBit};
    addCarry = addSum[WIDTH];
    addOvf   = (addX[MSB] == addYEff[MSB]) && (addSum[MSB] != addX[MSB]);
  end

  // Bitwise unit, one slice per bit
  logic [WIDTH-1:0] logicOut;

  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    always_comb begin
      unique case (strb.lfn)
        LG_AND:  logicOut[i] = opA[i] & opB[i];
        LG_ORR:  logicOut[i] = opA[i] | opB[i];
        LG_XOR:  logicOut[i] = opA[i] ^ opB[i];
        LG_BIC:  logicOut[i] = opA[i] & ~opB[i];
        LG_PASS: logicOut[i] = opB[i];
        LG_INV:  logicOut[i] = ~opB[i];
        default: logicOut[i] = 1'b0;
      endcase
    end
  end

  // Low-word multiply with optional accumulate
  logic [WIDTH-1:0] mulLow, mulOut;

  always_comb begin
    mulLow = opA * opB;
    mulOut = mulLow + (strb.accum ? opC : '0);
  end

  // Result select
  always_comb begin
    unique case (strb.src)
      SRC_LOGIC: result = logicOut;
      SRC_MUL:   result = mulOut;
      default:   result = addSum[MSB:0];
    endcase
  end

  // Flag register
  aluFlags_t flagD;

  always_comb begin
    flagD = flagQ;
    if (strb.ldNZ) begin
      flagD.n = result[MSB];
      flagD.z = (result == '0);
    end
    if (strb.ldCV) begin
      flagD.c = addCarry;
      flagD.v = addOvf;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagD;
  end

endmodule

// File: rtl/flagAlu.sv
module flagAlu
  import flagalu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [3:0]       opSel,
  input  logic             setFlags,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] opC,
  output logic [WIDTH-1:0] resOut,
  output logic             resWe,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV
);

  aluStrobe_t strb;
  aluFlags_t  flags;

  alu_ctrl uCtrl (
    .opSel    (opSel),
    .opValid  (opValid),
    .setFlags (setFlags),
    .strb     (strb)
  );

  alu_datapath #(.WIDTH(WIDTH)) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .opC    (opC),
    .strb   (strb),
    .result (resOut),
    .flagQ  (flags)
  );

  assign resWe = strb.wrResult;
  assign flagN = flags.n;
  assign flagZ = flags.z;
  assign flagC = flags.c;
  assign flagV = flags.v;

endmodule

// File: rtl/flagAlu_chk.sv
module flagAlu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [3:0]       opSel,
  input logic             setFlags,
  input logic [WIDTH-1:0] resOut,
  input logic             resWe,
  input logic             flagN,
  input logic             flagZ,
  input logic             flagC,
  input logic             flagV
);

  logic isCmp;
  logic keepsCV;

  assign isCmp   = (opSel[3:2] == 2'b10);
  assign keepsCV = !(opSel inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd8, 4'd9});

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && (setFlags || isCmp)) |=> $stable({flagN, flagZ, flagC, flagV})); // R7

  AST_CV_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && keepsCV) |=> $stable({flagC, flagV})); // R8

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    isCmp |-> !resWe); // R9

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |-> !resWe); // R10

  AST_WRITE_ON_RESULT_OP: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !isCmp) |-> resWe); // R10

  AST_Z_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && setFlags) |=> (flagZ == ($past(resOut) == '0))); // R3

  AST_N_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (resWe && setFlags) |=> (flagN == $past(resOut[WIDTH-1]))); // R3

endmodule

bind flagAlu flagAlu_chk #(.WIDTH(WIDTH)) uChk (.*);

// File: tb/sim_flagAlu.sv
`timescale 1ns/1ps
module sim_flagAlu;

  localparam int W = 32;
  localparam int NV = 24;
  // row: op[4] valid[1] setF[1] a[32] b[32] c[32] res[32] we[1] nzcv[4]
  localparam int RW = 4 + 1 + 1 + 4*W + 1 + 4;

  localparam logic [RW-1:0] TBL [NV] = '{
    {4'd0,  1'b1, 1'b1, 32'hFFFFFFFF, 32'h1,        32'h0, 32'h0,        1'b1, 4'b0110},
    {4'd1,  1'b1, 1'b1, 32'h0,        32'h0,        32'h0, 32'h1,        1'b1, 4'b0000},
    {4'd0,  1'b1, 1'b1, 32'h7FFFFFFF, 32'h1,        32'h0, 32'h80000000, 1'b1, 4'b1001},
    {4'd2,  1'b1, 1'b1, 32'h5,        32'h3,        32'h0, 32'h2,        1'b1, 4'b0010},
    {4'd2,  1'b1, 1'b1, 32'h3,        32'h5,        32'h0, 32'hFFFFFFFE, 1'b1, 4'b1000},
    {4'd3,  1'b1, 1'b1, 32'h3,        32'h5,        32'h0, 32'h2,        1'b1, 4'b0010},
    {4'd4,  1'b1, 1'b1, 32'hF0F00000, 32'hFF000000, 32'h0, 32'hF0000000, 1'b1, 4'b1010},
    {4'd5,  1'b1, 1'b0, 32'h0000000F, 32'h000000F0, 32'h0, 32'h000000FF, 1'b1, 4'b1010},
    {4'd6,  1'b1, 1'b1, 32'h1234,     32'h1234,     32'h0, 32'h0,        1'b1, 4'b0110},
    {4'd7,  1'b1, 1'b1, 32'hFF,       32'h0F,       32'h0, 32'hF0,       1'b1, 4'b0010},
    {4'd3,  1'b1, 1'b1, 32'h7,        32'h0,        32'h0, 32'hFFFFFFF9, 1'b1, 4'b1000},
    {4'd12, 1'b1, 1'b1, 32'hDEAD,     32'h0,        32'h0, 32'h0,        1'b1, 4'b0100},
    {4'd13, 1'b1, 1'b1, 32'hBEEF,     32'h0,        32'h0, 32'hFFFFFFFF, 1'b1, 4'b1000},
    {4'd14, 1'b1, 1'b1, 32'h10000,    32'h10000,    32'h0, 32'h0,        1'b1, 4'b0100},
    {4'd14, 1'b1, 1'b0, 32'h6,        32'h7,        32'h0, 32'h2A,       1'b1, 4'b0100},
    {4'd15, 1'b1, 1'b1, 32'h3,        32'h4,        32'hA, 32'h16,       1'b1, 4'b0000},
    {4'd8,  1'b1, 1'b0, 32'h5,        32'h5,        32'h0, 32'h0,        1'b0, 4'b0110},
    {4'd9,  1'b1, 1'b1, 32'h80000000, 32'h80000000, 32'h0, 32'h0,        1'b0, 4'b0111},
    {4'd10, 1'b1, 1'b1, 32'h80000000, 32'h80000001, 32'h0, 32'h0,        1'b0, 4'b1011},
    {4'd11, 1'b1, 1'b1, 32'h5,        32'h5,        32'h0, 32'h0,        1'b0, 4'b0111},
    {4'd0,  1'b0, 1'b1, 32'h1,        32'h1,        32'h0, 32'h0,        1'b0, 4'b0111},
    {4'd2,  1'b1, 1'b1, 32'h80000000, 32'h1,        32'h0, 32'h7FFFFFFF, 1'b1, 4'b0011},
    {4'd1,  1'b1, 1'b1, 32'hFFFFFFFF, 32'h0,        32'h0, 32'h0,        1'b1, 4'b0110},
    {4'd1,  1'b1, 1'b1, 32'h1,        32'h2,        32'h0, 32'h4,        1'b1, 4'b0000}
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [3:0]   opSel = '0;
  logic         setFlags = 1'b0;
  logic [W-1:0] opA = '0, opB = '0, opC = '0;
  logic [W-1:0] resOut;
  logic         resWe, flagN, flagZ, flagC, flagV;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flagAlu #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .setFlags(setFlags),
    .opA(opA), .opB(opB), .opC(opC), .resOut(resOut), .resWe(resWe),
    .flagN(flagN), .flagZ(flagZ), .flagC(flagC), .flagV(flagV)
  );

  task automatic check(input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  function automatic string resTag(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:         return "R1 add";
      4'd2, 4'd3:         return "R2 subtract";
      4'd4, 4'd5, 4'd6, 4'd7: return "R4 bitwise";
      4'd12, 4'd13:       return "R5 move";
      4'd14, 4'd15:       return "R6 multiply";
      default:            return "R9 compare";
    endcase
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: flags clear during and after reset
    check("R11 flags in reset", {28'd0, flagN, flagZ, flagC, flagV}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 flags after reset", {28'd0, flagN, flagZ, flagC, flagV}, '0);
    check("R10 idle write-enable", {31'd0, resWe}, '0);

    for (int i = 0; i < NV; i++) begin
      logic [RW-1:0] row;
      row = TBL[i];
      @(negedge clk);
      opSel    = row[RW-1 -: 4];
      opValid  = row[RW-5];
      setFlags = row[RW-6];
      opA      = row[RW-7 -: W];
      opB      = row[RW-7-W -: W];
      opC      = row[RW-7-2*W -: W];
      #1;
      if (row[4]) check($sformatf("%s row %0d result", resTag(opSel), i), resOut, row[5 +: W]);
      check($sformatf("R10 R9 row %0d write-enable", i), {31'd0, resWe}, {31'd0, row[4]});
      @(posedge clk);
      #1;
      check($sformatf("R3 R7 R8 R9 row %0d flags NZCV", i),
            {28'd0, flagN, flagZ, flagC, flagV}, {28'd0, row[3:0]});
    end

    // R11: reset in mid-run clears set flags
    @(negedge clk);
    opSel = 4'd0; opValid = 1'b1; setFlags = 1'b1; opA = 32'hFFFFFFFF; opB = 32'h1;
    @(posedge clk); #1;
    check("R1 carry before reset", {28'd0, flagN, flagZ, flagC, flagV}, 32'h6);
    opValid = 1'b0;
    rstN = 1'b0;
    #1;
    check("R11 mid-run reset flags", {28'd0, flagN, flagZ, flagC, flagV}, '0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: add-with-carry after reset sees a cleared carry
    opSel = 4'd1; opValid = 1'b1; setFlags = 1'b0; opA = 32'h10; opB = 32'h20;
    #1;
    check("R1 adc with cleared carry", resOut, 32'h30);
    @(posedge clk); #1;
    check("R7 no setFlags keeps flags", {28'd0, flagN, flagZ, flagC, flagV}, '0);

    summary();
  end

endmodule